// File: doc/BRIEF.md
# Vectored Exception Priority Resolver

This block looks at every pending trap and interrupt request and selects the single exception that should be serviced next. It merges two kinds of source into one 4-bit priority space. Traps occupy the upper half (levels 8 to 15) with fixed levels. Interrupts occupy the lower half (levels 1 to 7), each with a 3-bit priority programmed per source. When two candidates share a level, the one with the lower vector index wins. Some trap slots are reserved and can never be chosen.

Requests, enables, per-source priorities and the current CPU level are captured into a snapshot register on every clock. The winner is resolved combinationally from that snapshot, and the result is registered. The outputs are a take-exception flag, the winner's vector index and the level the CPU moves to. An interrupt is taken only when its priority is strictly above the current CPU level. A trap is taken whatever the CPU level is. Fetching the vector and saving context belong to other blocks.

Top module: `exc_prio_resolver`

## Requirements
- R1: While reset is asserted, `take_o`, `vec_o` and `lvl_o` are all zero, even with requests present.
- R2: Trap slots whose bit is set in `RSVD_MASK` are never selected. The default mask 0xE1 reserves trap slots 0, 5, 6 and 7, and a request on one of these slots alone gives `take_o` = 0.
- R3: Trap slot i (vector i, 0..7) has the fixed level 15 - i. Any active unreserved trap beats every interrupt, including one at priority 7.
- R4: An unreserved trap is taken even when the CPU level is 7.
- R5: Interrupt source k maps to vector 8 + k (8..61). Its priority is bits [3k+2:3k] of `irq_prio`, and the new level `lvl_o` equals that priority.
- R6: An interrupt whose `irq_en` bit is 0 is ignored. A lower-priority enabled request still wins over it.
- R7: An interrupt with priority 0 is never selected.
- R8: An interrupt is taken only when its priority is strictly greater than `cpu_ipl`. An equal level is not enough.
- R9: Among eligible requests, the one with the highest level wins.
- R10: Among requests of equal level, the lower vector index wins.
- R11: Each result appears after the second rising clock edge following an input change. While `take_o` is 0, `vec_o` and `lvl_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 8 | Trap request lines, bit i is trap vector i |
| irq_req | input | 54 | Interrupt request lines, bit k is source k |
| irq_en | input | 54 | Per-source interrupt enable |
| irq_prio | input | 162 | Packed 3-bit priority per source, source k at [3k+2:3k] |
| cpu_ipl | input | 3 | Current CPU priority level |
| take_o | output | 1 | An exception is to be taken |
| vec_o | output | 6 | Vector index of the winner |
| lvl_o | output | 4 | New CPU priority level (winner's level) |

## Verification
Every input reaches the outputs through two registers: the snapshot stage and the output stage. A change is therefore visible only after the second rising edge that follows it. The bench changes inputs at a falling edge, waits for two rising edges and samples at the next falling edge. A dedicated timing scenario also samples after only one edge, and confirms that the old result is still present both when a request rises and when it falls. The interrupt-level checker compares the taken level against the CPU level held in the snapshot one cycle earlier, which keeps it aligned to the same two-stage path.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

   // Class of the winning candidate, decided from its merged level
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_TRAP = 2'd1,
      SRC_IRQ  = 2'd2
   } src_kind_e;

   // Fixed level of trap slot idx: top of the merged space downward
   function automatic int unsigned trap_level(input int unsigned idx,
                                              input int unsigned prio_w,
                                              input int unsigned n_traps);
      return (2 ** prio_w) + (n_traps - 1 - idx);
   endfunction

endpackage

// File: rtl/exc_level_map.sv
module exc_level_map #(
   parameter int unsigned NUM_TRAPS = 8,
   parameter int unsigned NUM_IRQ   = 54,
   parameter int unsigned PRIO_W    = 3,
   parameter int unsigned RSVD_MASK = 'hE1
) (
   input  logic [NUM_TRAPS-1:0]                        trap_pend,
   input  logic [NUM_IRQ-1:0]                          irq_pend,
   input  logic [NUM_IRQ*PRIO_W-1:0]                   irq_prio,
   output logic [(NUM_TRAPS+NUM_IRQ)*(PRIO_W+1)-1:0]   lvl_flat
);
   import exc_prio_pkg::*;

   localparam int unsigned LVL_W   = PRIO_W + 1;
   localparam int unsigned NUM_VEC = NUM_TRAPS + NUM_IRQ;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      if (v < NUM_TRAPS) begin : g_trap
         localparam bit          IS_RSVD = ((RSVD_MASK >> v) & 1) != 0;
         localparam logic [LVL_W-1:0] FIX_LVL =
            LVL_W'(trap_level(v, PRIO_W, NUM_TRAPS));
         if (IS_RSVD) begin : g_rsvd
            assign lvl_flat[v*LVL_W +: LVL_W] = '0;
         end else begin : g_live
            assign lvl_flat[v*LVL_W +: LVL_W] = trap_pend[v] ? FIX_LVL : '0;
         end
      end else begin : g_irq
         localparam int unsigned K = v - NUM_TRAPS;
         // priority 0 yields level 0, which the picker treats as empty
         assign lvl_flat[v*LVL_W +: LVL_W] =
            irq_pend[K] ? {1'b0, irq_prio[K*PRIO_W +: PRIO_W]} : '0;
      end
   end

endmodule

// File: rtl/exc_max_pick.sv
module exc_max_pick #(
   parameter int unsigned NUM_VEC = 62,
   parameter int unsigned LVL_W   = 4,
   parameter int unsigned VEC_W   = 6
) (
   input  logic [NUM_VEC*LVL_W-1:0] lvl_flat,
   output logic [LVL_W-1:0]         best_lvl,
   output logic [VEC_W-1:0]         best_idx
);

   // Scan from the top index down; ">=" lets a lower index take a tie
   always_comb begin
      best_lvl = '0;
      best_idx = '0;
      for (int i = NUM_VEC - 1; i >= 0; i--) begin
         if ((lvl_flat[i*LVL_W +: LVL_W] != '0) &&
             (lvl_flat[i*LVL_W +: LVL_W] >= best_lvl)) begin
            best_lvl = lvl_flat[i*LVL_W +: LVL_W];
            best_idx = VEC_W'(i);
         end
      end
   end

endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver #(
   parameter int unsigned NUM_TRAPS = 8,
   parameter int unsigned NUM_IRQ   = 54,
   parameter int unsigned PRIO_W    = 3,
   parameter int unsigned RSVD_MASK = 'hE1,
   parameter int unsigned VEC_W     = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_TRAPS-1:0]       trap_req,
   input  logic [NUM_IRQ-1:0]         irq_req,
   input  logic [NUM_IRQ-1:0]         irq_en,
   input  logic [NUM_IRQ*PRIO_W-1:0]  irq_prio,
   input  logic [PRIO_W-1:0]          cpu_ipl,
   output logic                       take_o,
   output logic [VEC_W-1:0]           vec_o,
   output logic [PRIO_W:0]            lvl_o
);
   import exc_prio_pkg::*;

   localparam int unsigned LVL_W   = PRIO_W + 1;
   localparam int unsigned NUM_VEC = NUM_TRAPS + NUM_IRQ;

   // elaboration-time parameter checks
   if (NUM_TRAPS > 2 ** PRIO_W) begin : g_chk_traps
      $error("trap count exceeds upper level band");
   end
   if (NUM_TRAPS > 32) begin : g_chk_mask
      $error("reserved mask holds at most 32 trap slots");
   end
   if (NUM_VEC > 2 ** VEC_W) begin : g_chk_vec
      $error("vector index width too small");
   end
   if (NUM_IRQ < 1) begin : g_chk_irq
      $error("at least one interrupt source required");
   end

   // snapshot stage
   logic [NUM_TRAPS-1:0]      trap_q;
   logic [NUM_IRQ-1:0]        irq_q;
   logic [NUM_IRQ*PRIO_W-1:0] prio_q;
   logic [PRIO_W-1:0]         ipl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_q <= '0;
         irq_q  <= '0;
         prio_q <= '0;
         ipl_q  <= '0;
      end else begin
         trap_q <= trap_req;
         irq_q  <= irq_req & irq_en;
         prio_q <= irq_prio;
         ipl_q  <= cpu_ipl;
      end
   end

   // combinational resolution
   logic [NUM_VEC*LVL_W-1:0] lvl_flat;
   logic [LVL_W-1:0]         best_lvl;
   logic [VEC_W-1:0]         best_idx;

   exc_level_map #(
      .NUM_TRAPS (NUM_TRAPS),
      .NUM_IRQ   (NUM_IRQ),
      .PRIO_W    (PRIO_W),
      .RSVD_MASK (RSVD_MASK)
   ) map_i (
      .trap_pend (trap_q),
      .irq_pend  (irq_q),
      .irq_prio  (prio_q),
      .lvl_flat  (lvl_flat)
   );

   exc_max_pick #(
      .NUM_VEC (NUM_VEC),
      .LVL_W   (LVL_W),
      .VEC_W   (VEC_W)
   ) pick_i (
      .lvl_flat (lvl_flat),
      .best_lvl (best_lvl),
      .best_idx (best_idx)
   );

   src_kind_e kind;
   logic      eligible;

   always_comb begin
      if (best_lvl == '0)         kind = SRC_NONE;
      else if (best_lvl[PRIO_W])  kind = SRC_TRAP;
      else                        kind = SRC_IRQ;
      case (kind)
         SRC_TRAP: eligible = 1'b1;
         SRC_IRQ:  eligible = best_lvl[PRIO_W-1:0] > ipl_q;
         default:  eligible = 1'b0;
      endcase
   end

   // output stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_o <= 1'b0;
         vec_o  <= '0;
         lvl_o  <= '0;
      end else begin
         take_o <= eligible;
         vec_o  <= eligible ? best_idx : '0;
         lvl_o  <= eligible ? best_lvl : '0;
      end
   end

endmodule

// File: rtl/exc_prio_resolver_chk.sv
module exc_prio_resolver_chk #(
   parameter int unsigned NUM_TRAPS = 8,
   parameter int unsigned NUM_IRQ   = 54,
   parameter int unsigned PRIO_W    = 3,
   parameter int unsigned RSVD_MASK = 'hE1,
   parameter int unsigned VEC_W     = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  take_o,
   input logic [VEC_W-1:0]      vec_o,
   input logic [PRIO_W:0]       lvl_o,
   input logic [PRIO_W-1:0]     ipl_q,
   input logic [NUM_TRAPS-1:0]  trap_q
);
   localparam int unsigned NUM_VEC = NUM_TRAPS + NUM_IRQ;
   localparam logic [NUM_TRAPS-1:0] LIVE_TRAPS = ~NUM_TRAPS'(RSVD_MASK);

   AST_RSVD_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && vec_o < VEC_W'(NUM_TRAPS)) |-> (((RSVD_MASK >> vec_o) & 1) == 0)); // R2

   AST_TRAP_UPPER_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && vec_o < VEC_W'(NUM_TRAPS)) |-> lvl_o >= (PRIO_W+1)'(2 ** PRIO_W)); // R3

   AST_TRAP_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(|(trap_q & LIVE_TRAPS)) |-> (take_o && vec_o < VEC_W'(NUM_TRAPS))); // R4

   AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> vec_o < VEC_W'(NUM_VEC)); // R5

   AST_IRQ_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && vec_o >= VEC_W'(NUM_TRAPS)) |->
         (!lvl_o[PRIO_W] && lvl_o[PRIO_W-1:0] > $past(ipl_q))); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> (vec_o == '0 && lvl_o == '0)); // R11

endmodule

bind exc_prio_resolver exc_prio_resolver_chk #(
   .NUM_TRAPS (NUM_TRAPS),
   .NUM_IRQ   (NUM_IRQ),
   .PRIO_W    (PRIO_W),
   .RSVD_MASK (RSVD_MASK),
   .VEC_W     (VEC_W)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .take_o (take_o),
   .vec_o  (vec_o),
   .lvl_o  (lvl_o),
   .ipl_q  (ipl_q),
   .trap_q (trap_q)
);

// File: tb/exc_prio_resolver_tb_top.sv
`timescale 1ns/1ps
module exc_prio_resolver_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   trap_req = '0;
   logic [53:0]  irq_req = '0;
   logic [53:0]  irq_en = '0;
   logic [161:0] irq_prio = '0;
   logic [2:0]   cpu_ipl = '0;
   logic         take_o;
   logic [5:0]   vec_o;
   logic [3:0]   lvl_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   exc_prio_resolver dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .trap_req (trap_req),
      .irq_req  (irq_req),
      .irq_en   (irq_en),
      .irq_prio (irq_prio),
      .cpu_ipl  (cpu_ipl),
      .take_o   (take_o),
      .vec_o    (vec_o),
      .lvl_o    (lvl_o)
   );

   task automatic check_out(input string req, input bit et, input int ev, input int el);
      n_checks++;
      if (take_o !== et || int'(vec_o) != ev || int'(lvl_o) != el) begin
         n_fail++;
         $display("FAIL %s: actual take=%0d vec=%0d lvl=%0d expected take=%0d vec=%0d lvl=%0d",
                  req, take_o, vec_o, lvl_o, et, ev, el);
      end
   endtask

   task automatic clear_inputs();
      trap_req = '0; irq_req = '0; irq_en = '0; irq_prio = '0; cpu_ipl = '0;
   endtask

   task automatic add_irq(input int k, input int prio, input bit en);
      irq_req[k] = 1'b1;
      irq_en[k]  = en;
      irq_prio[k*3 +: 3] = 3'(prio);
   endtask

   // inputs set at a falling edge, result sampled after two rising edges
   task automatic settle();
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      trap_req = 8'h02;
      repeat (3) @(negedge clk);
      check_out("R1 outputs held clear in reset", 0, 0, 0);
      rst_n = 1'b1;
      clear_inputs();
      settle();
   endtask

   task automatic t_reserved();
      int slots[4] = '{0, 5, 6, 7};
      foreach (slots[s]) begin
         clear_inputs();
         trap_req[slots[s]] = 1'b1;
         settle();
         check_out($sformatf("R2 reserved trap %0d ignored", slots[s]), 0, 0, 0);
      end
   endtask

   task automatic t_trap_levels();
      clear_inputs(); trap_req[1] = 1'b1; settle();
      check_out("R3 trap 1 level 14", 1, 1, 14);
      clear_inputs(); trap_req[4] = 1'b1; settle();
      check_out("R3 trap 4 level 11", 1, 4, 11);
      clear_inputs(); trap_req[1] = 1'b1; trap_req[4] = 1'b1; settle();
      check_out("R3 trap 1 over trap 4", 1, 1, 14);
      clear_inputs(); trap_req[3] = 1'b1; add_irq(0, 7, 1); settle();
      check_out("R3 trap beats priority-7 interrupt", 1, 3, 12);
      clear_inputs(); trap_req[0] = 1'b1; add_irq(5, 6, 1); settle();
      check_out("R2 reserved trap leaves interrupt to win", 1, 13, 6);
   endtask

   task automatic t_trap_ipl();
      clear_inputs(); trap_req[2] = 1'b1; cpu_ipl = 3'd7; settle();
      check_out("R4 trap taken at cpu level 7", 1, 2, 13);
   endtask

   task automatic t_irq_map();
      clear_inputs(); add_irq(10, 5, 1); settle();
      check_out("R5 source 10 vector 18", 1, 18, 5);
      clear_inputs(); add_irq(53, 1, 1); settle();
      check_out("R5 last source vector 61", 1, 61, 1);
   endtask

   task automatic t_enable();
      clear_inputs(); add_irq(10, 6, 0); settle();
      check_out("R6 disabled source ignored", 0, 0, 0);
      clear_inputs(); add_irq(10, 6, 0); add_irq(20, 2, 1); settle();
      check_out("R6 enabled lower priority wins over disabled", 1, 28, 2);
   endtask

   task automatic t_prio_zero();
      clear_inputs(); add_irq(3, 0, 1); settle();
      check_out("R7 priority 0 never taken", 0, 0, 0);
   endtask

   task automatic t_ipl();
      clear_inputs(); add_irq(7, 4, 1); cpu_ipl = 3'd4; settle();
      check_out("R8 equal level blocked", 0, 0, 0);
      cpu_ipl = 3'd3; settle();
      check_out("R8 one above level taken", 1, 15, 4);
      clear_inputs(); add_irq(9, 7, 1); cpu_ipl = 3'd7; settle();
      check_out("R8 priority 7 blocked at level 7", 0, 0, 0);
   endtask

   task automatic t_highest();
      clear_inputs(); add_irq(2, 3, 1); add_irq(40, 6, 1); settle();
      check_out("R9 higher priority at higher index wins", 1, 48, 6);
   endtask

   task automatic t_tie();
      clear_inputs(); add_irq(30, 5, 1); add_irq(12, 5, 1); add_irq(50, 5, 1); settle();
      check_out("R10 tie goes to lower vector", 1, 20, 5);
   endtask

   task automatic t_timing();
      clear_inputs(); settle();
      add_irq(4, 2, 1);
      @(posedge clk); @(negedge clk);
      check_out("R11 not visible after one edge", 0, 0, 0);
      @(posedge clk); @(negedge clk);
      check_out("R11 visible after two edges", 1, 12, 2);
      clear_inputs();
      @(posedge clk); @(negedge clk);
      check_out("R11 held one edge after release", 1, 12, 2);
      @(posedge clk); @(negedge clk);
      check_out("R11 cleared two edges after release", 0, 0, 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_reserved();
      t_trap_levels();
      t_trap_ipl();
      t_irq_map();
      t_enable();
      t_prio_zero();
      t_ipl();
      t_highest();
      t_tie();
      t_timing();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual run still busy, expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule